// File: doc/BRIEF.md
# E1 Frame and Multiframe Pulse Generator

This block produces a one-cycle marker on the receive side of an E1 link. It counts receive clock cycles across the 256-bit frame. It also keeps two separate 16-frame position counters. One follows CRC multiframe alignment and the other follows signaling multiframe alignment. The two phases are allowed to differ. An upstream framer supplies three strobes: one for frame alignment, one for the CRC multiframe and one for the signaling multiframe. Each strobe realigns its own counter.

A 2-bit select picks the pulse meaning:
- `00`: the start of every frame.
- `01`: the start of the CRC multiframe.
- `10`: the start of the signaling multiframe.
- `11`: same as `00`.

When no multiframe strobes arrive, for example when multiframing is off upstream, the multiframe counters run freely. The output then still marks every 16th frame. Since 16 is even, the marked frame keeps the same frame-alignment parity it started with.

Top module: `e1_frame_pulse_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first frame-alignment strobe, `frame_pulse` stays low.
- R2: `frame_pulse` is high for exactly one cycle. It is never high in two consecutive cycles unless a frame-alignment strobe arrives in the second of them.
- R3: With `pulse_sel` = `00`, the pulse appears in the bit-1 cycle of every frame, so it repeats every 256 cycles.
- R4: With `pulse_sel` = `01`, the pulse appears only in the bit-1 cycle of CRC multiframe frame 1.
- R5: With `pulse_sel` = `10`, the pulse appears only in the bit-1 cycle of signaling multiframe frame 1.
- R6: `pulse_sel` = `11` gives the same output as `00`.
- R7: A frame-alignment strobe makes its own cycle bit 1, so the pulse can fire in that same cycle. The next bit-1 cycle follows 256 cycles later.
- R8: A CRC strobe resets only the CRC counter to frame 1, and a signaling strobe resets only the signaling counter. A strobe for one counter leaves the other counter's phase unchanged.
- R9: Both frame counters advance only when the bit counter wraps from 256 to 1, and each wraps from 16 back to 1. If no multiframe strobes arrive, codes `01` and `10` pulse every 16 frames (4096 cycles).
- R10: `pulse_sel` is examined only in a bit-1 cycle. A change made mid-frame therefore takes effect at the next frame boundary and cannot create a runt pulse or an extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fas_strobe | input | 1 | Frame-alignment strobe; marks bit 1 in this cycle |
| crc_mf_strobe | input | 1 | CRC multiframe strobe; marks CRC frame 1 |
| sig_mf_strobe | input | 1 | Signaling multiframe strobe; marks signaling frame 1 |
| pulse_sel | input | 2 | Pulse meaning: 00 frame, 01 CRC multiframe, 10 signaling multiframe, 11 as 00 |
| frame_pulse | output | 1 | One-cycle alignment pulse |

## Verification
Several properties are checked every cycle:
- The output stays quiet before alignment.
- Pulses are a single cycle long.
- A frame-alignment strobe forces bit 1.
- The frame counters hold between bit wraps and roll over from 16 to 1.
- A multiframe-coded pulse only appears when the chosen counter is at frame 1.

Some behaviour can only be shown by the bench's scenarios. These are the exact 256- and 4096-cycle spacing and the deferral of a select change to the next frame. The bench also shows that a signaling strobe leaves the CRC phase untouched, and that a mid-frame realignment moves every later pulse.

// File: rtl/e1_frame_pulse_gen.sv
module e1_frame_pulse_gen #(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fas_strobe,
  input  logic       crc_mf_strobe,
  input  logic       sig_mf_strobe,
  input  logic [1:0] pulse_sel,
  output logic       frame_pulse
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(MF_FRAMES);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(MF_FRAMES - 1);

  logic [BW-1:0] bit_q, bit_cur;
  logic [FW-1:0] crc_q, crc_cur, sig_q, sig_cur;
  logic          synced_q, frame_end, sel_hit;

  // current position: a strobe overrides the stored count in its own cycle
  assign bit_cur   = fas_strobe    ? '0 : bit_q;
  assign crc_cur   = crc_mf_strobe ? '0 : crc_q;
  assign sig_cur   = sig_mf_strobe ? '0 : sig_q;
  assign frame_end = (bit_cur == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q    <= '0;
      crc_q    <= '0;
      sig_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      bit_q    <= frame_end ? '0 : bit_cur + BW'(1);
      if (frame_end) begin
        crc_q <= (crc_cur == FRM_LAST) ? '0 : crc_cur + FW'(1);
        sig_q <= (sig_cur == FRM_LAST) ? '0 : sig_cur + FW'(1);
      end else begin
        crc_q <= crc_cur;
        sig_q <= sig_cur;
      end
      synced_q <= synced_q | fas_strobe;
    end
  end

  always_comb begin
    case (pulse_sel)
      2'b01:   sel_hit = (crc_cur == '0);
      2'b10:   sel_hit = (sig_cur == '0);
      default: sel_hit = 1'b1;
    endcase
  end

  assign frame_pulse = rst_n & (synced_q | fas_strobe) & (bit_cur == '0) & sel_hit;

  p_quiet_before_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced_q && !fas_strobe) |-> !frame_pulse);

  p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (!frame_pulse || fas_strobe));

  p_crc_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && pulse_sel == 2'b01) |-> (crc_mf_strobe || crc_q == '0));

  p_sig_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && pulse_sel == 2'b10) |-> (sig_mf_strobe || sig_q == '0));

  p_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fas_strobe |=> (bit_q == BW'(1)));

  p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q != BIT_LAST && !fas_strobe && !crc_mf_strobe) |=> $stable(crc_q));

  p_sig_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q != BIT_LAST && !fas_strobe && !sig_mf_strobe) |=> $stable(sig_q));

  p_crc_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q == BIT_LAST && !fas_strobe && !crc_mf_strobe && crc_q == FRM_LAST) |=> (crc_q == '0));
endmodule

// File: tb/e1_frame_pulse_gen_tb.sv
`timescale 1ns/1ps
module e1_frame_pulse_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fas = 1'b0, crc = 1'b0, sig = 1'b0;
  logic [1:0] sel = 2'b00;
  logic pulse;
  int cyc = 0;
  int checks = 0, errors = 0;
  int exp_cyc[$];
  string exp_tag[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  e1_frame_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .fas_strobe(fas), .crc_mf_strobe(crc),
    .sig_mf_strobe(sig), .pulse_sel(sel), .frame_pulse(pulse)
  );

  task automatic expect_at(input int c, input string tag);
    exp_cyc.push_back(c);
    exp_tag.push_back(tag);
  endtask

  task automatic goto(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares observed pulses against the expected queue
  always @(negedge clk) begin
    #1;
    if (!done) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        check(1'b0, {exp_tag[0], " missing pulse"}, cyc, exp_cyc[0]);
        void'(exp_cyc.pop_front());
        void'(exp_tag.pop_front());
      end
      if (pulse) begin
        if (exp_cyc.size() == 0) check(1'b0, "R2 unexpected pulse", cyc, -1);
        else begin
          check(exp_cyc[0] == cyc, exp_tag[0], cyc, exp_cyc[0]);
          void'(exp_cyc.pop_front());
          void'(exp_tag.pop_front());
        end
      end
    end
  end

  initial begin
    int c0;
    int base;
    repeat (3) @(negedge clk);
    fas = 1'b1;
    #1 check(pulse == 1'b0, "R1 pulse during reset", pulse, 0);
    @(negedge clk);
    fas = 1'b0;
    rst_n = 1'b1;
    // R1: no pulse for 300 cycles without a frame-alignment strobe
    repeat (300) @(negedge clk);

    // R3/R7: align everything
    c0 = cyc + 5;
    expect_at(c0, "R7 pulse in strobe cycle");
    expect_at(c0 + 256, "R3 frame pulse");
    expect_at(c0 + 512, "R3 frame pulse");
    expect_at(c0 + 768, "R6 code 11 pulse");
    expect_at(c0 + 1024, "R6 code 11 pulse");
    expect_at(c0 + 4096, "R4 CRC multiframe pulse");
    goto(c0);
    fas = 1'b1; crc = 1'b1; sig = 1'b1;
    @(negedge clk);
    fas = 1'b0; crc = 1'b0; sig = 1'b0;
    goto(c0 + 600);
    sel = 2'b11;                  // R6
    goto(c0 + 1100);
    sel = 2'b01;                  // R10 mid-frame change
    // R8: signaling strobe alone at frame 3 boundary; CRC phase unaffected
    goto(c0 + 4864);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    expect_at(c0 + 8192, "R9 CRC free-run 4096 cycles");
    goto(c0 + 8192 + 100);
    sel = 2'b10;
    expect_at(c0 + 8960, "R5 signaling multiframe pulse");
    expect_at(c0 + 13056, "R8 signaling phase independent");
    goto(c0 + 13056 + 50);
    sel = 2'b00;
    base = c0 + 13056;
    expect_at(base + 256, "R10 select change at boundary");
    expect_at(base + 512, "R3 frame pulse");
    expect_at(base + 768, "R3 frame pulse");
    expect_at(base + 1000, "R7 mid-frame realign");
    expect_at(base + 1256, "R7 new frame phase");
    goto(base + 1000);
    fas = 1'b1;
    @(negedge clk);
    fas = 1'b0;
    goto(base + 1400);
    #1;
    check(exp_cyc.size() == 0, "R3 all expected pulses seen", exp_cyc.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule